// File: doc/BRIEF.md
# VLIW Sequencer Control Unit

This block owns the program counter of a VLIW core that issues at most one bundle per clock. Each cycle it receives the already-decoded control op from one of the two scalar lanes, the signed 20-bit value from the bundle's shared immediate field, a predication code, the predicate-register file and one scalar-register read value. From these it forms the address of the next bundle to fetch. When a call executes it raises a write to the link register. It also raises a halted flag and an issue-stall flag.

Calls place their return address in an ordinary scalar register. A return is an indirect branch through that register. Every branch or call carries its own count of delay slots. The predication code acts as the branch condition, and one code marks an empty slot. A separate delay op stalls issue for a number of cycles without altering control flow. Fetch, bundle bit decoding and ALU execution all belong to neighbouring blocks.

`fetch_addr_o`, `illegal_o` and the link-write port are combinational from the current inputs and state. `pc_o` is the address of the bundle being presented in the current cycle.

Top module: `seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, the unit holds `pc_o` at 0 and clears the halted state, any pending branch and any issue stall.
- R2: A bundle is issued when `bundle_valid_i` is 1 and the unit is neither halted nor stalled. An issued no-op (op 0) or fence (op 8) gives `fetch_addr_o = pc_o + 1`. When no bundle is issued, `fetch_addr_o = pc_o`. `pc_o` takes the value of `fetch_addr_o` at each clock edge.
- R3: The target of an absolute branch (op 1) is the sign-extended immediate. The target of a relative branch (op 2) is `pc_o` plus the sign-extended immediate, wrapping modulo 2^PC_W.
- R4: An executing call sets `sreg_we_o`, places the link register index (5) on `sreg_waddr_o` and places `pc_o + 1` on `sreg_wdata_o`. Call ops are 4 (absolute), 5 (relative) and 6 (register). A call that does not execute writes nothing.
- R5: Register-indirect branch (op 3) and call (op 6) take their target from `sreg_rdata_i`. This is how a return is made.
- R6: A predication code from 0 to 14 executes the op only when the corresponding bit of `preg_i` is 1. Code 15 always executes. Code 31 marks an empty slot, which has no effect and is never reported as illegal.
- R7: A branch or call with delay count d (0..5) that executes at address p issues p+1 … p+d in sequence, then fetches its target. With d = 0 the target is fetched next.
- R8: A branch or call presented on lane 1 (`lane_i = 1`) raises `illegal_o`, advances sequentially and writes no link. Halt, fence and delay ops execute normally on lane 1.
- R9: A branch or call with a delay count above 5 is illegal. So is a branch or call that arrives while the delay slots of an earlier branch are still running. In both cases it advances sequentially, and the earlier branch still completes.
- R10: An executing delay op (op 9) with count n = `imm_i[7:0]` advances to p+1. It then holds `issue_stall_o` high for n cycles. During those cycles `fetch_addr_o = pc_o` and incoming bundles are ignored.
- R11: An executing halt (op 7) keeps `fetch_addr_o` at the halt's address and raises `halted_o` from the next cycle. The unit then keeps the PC frozen and ignores all bundles until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bundle_valid_i | input | 1 | A bundle is presented this cycle |
| lane_i | input | 1 | Scalar lane that carries the control op |
| op_i | input | 4 | Decoded control op code |
| imm_i | input | 20 | Shared immediate: target, offset or delay count |
| pred_i | input | PRED_W (5) | Predication code |
| delay_slots_i | input | 3 | Delay-slot count of a branch or call |
| preg_i | input | NUM_PREG (15) | Predicate register values |
| sreg_rdata_i | input | DATA_W (32) | Scalar register read data for indirect targets |
| pc_o | output | PC_W (24) | Address of the bundle presented this cycle |
| fetch_addr_o | output | PC_W (24) | Next fetch address |
| sreg_we_o | output | 1 | Link register write enable |
| sreg_waddr_o | output | 5 | Link register index |
| sreg_wdata_o | output | DATA_W (32) | Return address |
| illegal_o | output | 1 | Current control op rejected |
| issue_stall_o | output | 1 | Delay op stall in progress |
| halted_o | output | 1 | Core halted |

## Verification
The checker assumes that `bundle_valid_i` is low during reset and that no predication code from 16 to 30 is ever presented. It also assumes that the inputs settle between clock edges. The bench drives every input at the falling edge, holds `bundle_valid_i` low across both reset pulses and draws predication codes only from 0–14, 15 and 31. Corner cases such as a relative target wrapping below zero, branches inside delay slots and bundles offered during a stall or after a halt are all placed on legal input values, so every flag the unit raises comes from its own rules.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;
  localparam int IMM_W     = 20;
  localparam int DSLOT_W   = 3;
  localparam int MAX_DSLOT = 5;
  localparam int SREG_AW   = 5;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_BR_ABS   = 4'd1,
    OP_BR_REL   = 4'd2,
    OP_BR_REG   = 4'd3,
    OP_CALL_ABS = 4'd4,
    OP_CALL_REL = 4'd5,
    OP_CALL_REG = 4'd6,
    OP_HALT     = 4'd7,
    OP_FENCE    = 4'd8,
    OP_DELAY    = 4'd9
  } seq_op_e;

  function automatic logic op_is_call(seq_op_e op);
    return (op == OP_CALL_ABS) || (op == OP_CALL_REL) || (op == OP_CALL_REG);
  endfunction

  function automatic logic op_is_flow(seq_op_e op);
    return (op == OP_BR_ABS) || (op == OP_BR_REL) || (op == OP_BR_REG) || op_is_call(op);
  endfunction
endpackage

// File: rtl/seq_pred_eval.sv
module seq_pred_eval #(
  parameter int PRED_W   = 5,
  parameter int NUM_PREG = 15
) (
  input  logic [PRED_W-1:0]   pred_i,
  input  logic [NUM_PREG-1:0] preg_i,
  output logic                exec_o,
  output logic                empty_o
);
  localparam int IDX_W = 4;
  localparam int PAD_N = 1 << IDX_W;

  logic [PAD_N-1:0] preg_pad;
  assign preg_pad = {{(PAD_N-NUM_PREG){1'b0}}, preg_i};

  generate
    if (PRED_W == 5) begin : g_narrow
      // 0..14 predicate, 15 always, 31 empty, rest never
      localparam logic [4:0] ALWAYS_C = 5'd15;
      localparam logic [4:0] NEVER_C  = 5'd31;
      always_comb begin
        empty_o = (pred_i == NEVER_C);
        if (pred_i == ALWAYS_C)   exec_o = 1'b1;
        else if (!pred_i[4])      exec_o = preg_pad[pred_i[IDX_W-1:0]];
        else                      exec_o = 1'b0;
      end
    end else begin : g_wide
      // [3:0] index, [4] present, [6:5] mode
      logic [1:0] mode;
      logic       sel;
      assign mode = pred_i[6:5];
      assign sel  = preg_pad[pred_i[IDX_W-1:0]];
      always_comb begin
        empty_o = (mode == 2'd1);
        unique case (mode)
          2'd0:    exec_o = 1'b1;
          2'd1:    exec_o = 1'b0;
          2'd2:    exec_o = pred_i[4] & sel;
          default: exec_o = pred_i[4] & ~sel;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/seq_target_gen.sv
module seq_target_gen
  import seq_ctrl_pkg::*;
#(
  parameter int PC_W   = 24,
  parameter int DATA_W = 32
) (
  input  seq_op_e           op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] sreg_rdata_i,
  output logic [PC_W-1:0]   target_o
);
  logic [PC_W-1:0] imm_ext;

  generate
    if (PC_W > IMM_W) begin : g_sext
      assign imm_ext = {{(PC_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (op_i)
      OP_BR_REL, OP_CALL_REL: target_o = pc_i + imm_ext;
      OP_BR_REG, OP_CALL_REG: target_o = sreg_rdata_i[PC_W-1:0];
      default:                target_o = imm_ext;
    endcase
  end
endmodule

// File: rtl/seq_slot_tracker.sv
module seq_slot_tracker #(
  parameter int PC_W    = 24,
  parameter int DSLOT_W = 3,
  parameter int STALL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic               clear_i,
  input  logic               arm_i,
  input  logic [DSLOT_W-1:0] arm_cnt_i,
  input  logic [PC_W-1:0]    arm_tgt_i,
  input  logic               stall_ld_i,
  input  logic [STALL_W-1:0] stall_cnt_i,
  output logic               pend_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    pend_tgt_o,
  output logic               stall_o
);
  logic [DSLOT_W-1:0] pend_cnt_q;
  logic [PC_W-1:0]    pend_tgt_q;
  logic [STALL_W-1:0] stall_cnt_q;

  assign pend_o     = (pend_cnt_q != '0);
  assign redirect_o = issue_i && (pend_cnt_q == DSLOT_W'(1));
  assign pend_tgt_o = pend_tgt_q;
  assign stall_o    = (stall_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_cnt_q <= '0;
      pend_tgt_q <= '0;
    end else if (clear_i) begin
      pend_cnt_q <= '0;
    end else if (arm_i) begin
      pend_cnt_q <= arm_cnt_i;
      pend_tgt_q <= arm_tgt_i;
    end else if (issue_i && pend_o) begin
      pend_cnt_q <= pend_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stall_cnt_q <= '0;
    else if (stall_ld_i) stall_cnt_q <= stall_cnt_i;
    else if (stall_o)    stall_cnt_q <= stall_cnt_q - 1'b1;
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_ctrl_pkg::*;
#(
  parameter int PC_W     = 24,
  parameter int DATA_W   = 32,
  parameter int PRED_W   = 5,
  parameter int NUM_PREG = 15,
  parameter int STALL_W  = 8,
  parameter int LINK_REG = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bundle_valid_i,
  input  logic                lane_i,
  input  logic [3:0]          op_i,
  input  logic [19:0]         imm_i,
  input  logic [PRED_W-1:0]   pred_i,
  input  logic [2:0]          delay_slots_i,
  input  logic [NUM_PREG-1:0] preg_i,
  input  logic [DATA_W-1:0]   sreg_rdata_i,
  output logic [PC_W-1:0]     pc_o,
  output logic [PC_W-1:0]     fetch_addr_o,
  output logic                sreg_we_o,
  output logic [4:0]          sreg_waddr_o,
  output logic [DATA_W-1:0]   sreg_wdata_o,
  output logic                illegal_o,
  output logic                issue_stall_o,
  output logic                halted_o
);
  seq_op_e         op;
  logic [PC_W-1:0] pc_q, pc_d, seq_pc, target, pend_tgt;
  logic            halted_q;
  logic            exec, empty, run, is_flow, flow_bad, act;
  logic            pend, redirect, stall, arm, halt_go, delay_go;

  assign op = seq_op_e'(op_i);

  seq_pred_eval #(.PRED_W(PRED_W), .NUM_PREG(NUM_PREG)) u_pred (
    .pred_i  (pred_i),
    .preg_i  (preg_i),
    .exec_o  (exec),
    .empty_o (empty)
  );

  seq_target_gen #(.PC_W(PC_W), .DATA_W(DATA_W)) u_tgt (
    .op_i         (op),
    .pc_i         (pc_q),
    .imm_i        (imm_i),
    .sreg_rdata_i (sreg_rdata_i),
    .target_o     (target)
  );

  assign run      = bundle_valid_i && !halted_q && !stall;
  assign is_flow  = op_is_flow(op);
  assign flow_bad = run && is_flow && !empty &&
                    (lane_i || (delay_slots_i > DSLOT_W'(MAX_DSLOT)) || pend);
  assign act      = run && exec && !flow_bad;
  assign arm      = act && is_flow && (delay_slots_i != '0);
  assign halt_go  = act && (op == OP_HALT);
  assign delay_go = act && (op == OP_DELAY) && (imm_i[STALL_W-1:0] != '0);

  seq_slot_tracker #(.PC_W(PC_W), .DSLOT_W(DSLOT_W), .STALL_W(STALL_W)) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (run),
    .clear_i     (halt_go),
    .arm_i       (arm),
    .arm_cnt_i   (delay_slots_i),
    .arm_tgt_i   (target),
    .stall_ld_i  (delay_go),
    .stall_cnt_i (imm_i[STALL_W-1:0]),
    .pend_o      (pend),
    .redirect_o  (redirect),
    .pend_tgt_o  (pend_tgt),
    .stall_o     (stall)
  );

  assign seq_pc = redirect ? pend_tgt : pc_q + 1'b1;

  always_comb begin
    if (!run)                                           pc_d = pc_q;
    else if (halt_go)                                   pc_d = pc_q;
    else if (act && is_flow && delay_slots_i == '0)     pc_d = target;
    else                                                pc_d = seq_pc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      halted_q <= halted_q | halt_go;
    end
  end

  assign pc_o          = pc_q;
  assign fetch_addr_o  = pc_d;
  assign sreg_we_o     = act && op_is_call(op);
  assign sreg_waddr_o  = SREG_AW'(LINK_REG);
  assign sreg_wdata_o  = DATA_W'(pc_q + 1'b1);
  assign illegal_o     = flow_bad;
  assign issue_stall_o = stall;
  assign halted_o      = halted_q;
endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk #(
  parameter int PC_W     = 24,
  parameter int LINK_REG = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bundle_valid_i,
  input logic [PC_W-1:0] pc_o,
  input logic [PC_W-1:0] fetch_addr_o,
  input logic            sreg_we_o,
  input logic [4:0]      sreg_waddr_o,
  input logic            illegal_o,
  input logic            issue_stall_o,
  input logic            halted_o
);
  // R2
  pc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> pc_o == $past(fetch_addr_o));

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bundle_valid_i |-> fetch_addr_o == pc_o);

  // R11
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(pc_o));

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_stall_o |-> fetch_addr_o == pc_o && !sreg_we_o && !illegal_o);

  // R8
  illegal_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !sreg_we_o);

  // R4
  link_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreg_we_o |-> sreg_waddr_o == 5'(LINK_REG) && !halted_o);
endmodule

bind seq_ctrl seq_ctrl_chk #(.PC_W(PC_W), .LINK_REG(LINK_REG)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bundle_valid_i (bundle_valid_i),
  .pc_o           (pc_o),
  .fetch_addr_o   (fetch_addr_o),
  .sreg_we_o      (sreg_we_o),
  .sreg_waddr_o   (sreg_waddr_o),
  .illegal_o      (illegal_o),
  .issue_stall_o  (issue_stall_o),
  .halted_o       (halted_o)
);

// File: tb/seq_ctrl_bench.sv
module seq_ctrl_bench;
  localparam int PC_W = 24;
  localparam int DW   = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            bundle_valid_i = 1'b0;
  logic            lane_i = 1'b0;
  logic [3:0]      op_i = '0;
  logic [19:0]     imm_i = '0;
  logic [4:0]      pred_i = 5'd15;
  logic [2:0]      delay_slots_i = '0;
  logic [14:0]     preg_i = '0;
  logic [DW-1:0]   sreg_rdata_i = '0;
  logic [PC_W-1:0] pc_o, fetch_addr_o;
  logic            sreg_we_o, illegal_o, issue_stall_o, halted_o;
  logic [4:0]      sreg_waddr_o;
  logic [DW-1:0]   sreg_wdata_o;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [PC_W-1:0] m_pc;
  logic            m_halt;
  int              m_pend;
  logic [PC_W-1:0] m_ptgt;
  int              m_stall;
  // expected outputs and next state
  logic [PC_W-1:0] e_fa, n_ptgt;
  logic            e_we, e_ill, e_stall;
  int              n_pend, n_stall;
  logic            n_halt;

  always #5 clk_i = ~clk_i;

  seq_ctrl u_seq_ctrl (
    .clk_i, .rst_ni, .bundle_valid_i, .lane_i, .op_i, .imm_i, .pred_i,
    .delay_slots_i, .preg_i, .sreg_rdata_i, .pc_o, .fetch_addr_o,
    .sreg_we_o, .sreg_waddr_o, .sreg_wdata_o, .illegal_o, .issue_stall_o,
    .halted_o
  );

  task automatic model_reset();
    m_pc = '0; m_halt = 1'b0; m_pend = 0; m_ptgt = '0; m_stall = 0;
  endtask

  task automatic model_eval();
    logic exe, flow, call;
    logic [PC_W-1:0] tgt, seq;
    e_fa = m_pc; e_we = 0; e_ill = 0; e_stall = (m_stall > 0) && !m_halt;
    n_pend = m_pend; n_ptgt = m_ptgt; n_halt = m_halt;
    n_stall = (m_stall > 0) ? m_stall - 1 : 0;
    if (m_halt || m_stall > 0 || !bundle_valid_i) return;
    if (pred_i == 5'd15) exe = 1;
    else if (pred_i < 5'd15) exe = preg_i[pred_i];
    else exe = 0;
    flow = op_i inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6};
    call = op_i inside {4'd4, 4'd5, 4'd6};
    if (flow && pred_i != 5'd31 && (lane_i || delay_slots_i > 3'd5 || m_pend > 0)) e_ill = 1;
    seq = m_pc + 1;
    if (m_pend > 0) begin
      if (m_pend == 1) seq = m_ptgt;
      n_pend = m_pend - 1;
    end
    e_fa = seq;
    if (!exe || e_ill) return;
    case (op_i)
      4'd1, 4'd4: tgt = PC_W'($signed(imm_i));
      4'd2, 4'd5: tgt = m_pc + PC_W'($signed(imm_i));
      default:    tgt = sreg_rdata_i[PC_W-1:0];
    endcase
    if (flow) begin
      e_we = call;
      if (delay_slots_i == 0) e_fa = tgt;
      else begin n_pend = delay_slots_i; n_ptgt = tgt; end
    end else if (op_i == 4'd7) begin
      e_fa = m_pc; n_halt = 1; n_pend = 0;
    end else if (op_i == 4'd9) begin
      n_stall = imm_i[7:0];
    end
  endtask

  task automatic step(input string tag, input logic v, input logic ln, input logic [3:0] op,
                      input int imm, input logic [4:0] pr, input logic [2:0] ds,
                      input logic [DW-1:0] sr);
    logic bad;
    bundle_valid_i = v; lane_i = ln; op_i = op; imm_i = 20'(imm);
    pred_i = pr; delay_slots_i = ds; sreg_rdata_i = sr;
    #2;
    model_eval();
    bad = (fetch_addr_o !== e_fa) || (pc_o !== m_pc) || (illegal_o !== e_ill) ||
          (sreg_we_o !== e_we) || (halted_o !== m_halt) || (issue_stall_o !== e_stall) ||
          (e_we && sreg_wdata_o !== DW'(m_pc + 1'b1));
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: act fa=%0d pc=%0d ill=%0b we=%0b wd=%0d halt=%0b stall=%0b exp fa=%0d pc=%0d ill=%0b we=%0b wd=%0d halt=%0b stall=%0b",
               tag, fetch_addr_o, pc_o, illegal_o, sreg_we_o, sreg_wdata_o, halted_o, issue_stall_o,
               e_fa, m_pc, e_ill, e_we, m_pc + 1'b1, m_halt, e_stall);
    end
    @(posedge clk_i);
    m_pc = e_fa; m_halt = n_halt; m_pend = n_pend; m_ptgt = n_ptgt; m_stall = n_stall;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    bundle_valid_i = 0;
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    model_reset();
    checks++;
    // R1
    if (pc_o !== '0 || halted_o !== 0 || issue_stall_o !== 0) begin
      errors++;
      $display("FAIL R1: act pc=%0d halt=%0b stall=%0b exp pc=0 halt=0 stall=0",
               pc_o, halted_o, issue_stall_o);
    end
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    preg_i = 15'b000_0000_0000_0100;  // P2 set, P3 clear
    do_reset();
    step("R2", 0, 0, 4'd0, 0, 15, 0, 0);
    step("R2", 1, 0, 4'd0, 0, 15, 0, 0);
    step("R8", 1, 1, 4'd8, 0, 15, 0, 0);
    step("R3", 1, 0, 4'd1, 100, 15, 0, 0);
    step("R3", 1, 0, 4'd2, -3, 15, 0, 0);
    step("R3", 1, 0, 4'd2, -200, 15, 0, 0);
    step("R3", 1, 0, 4'd1, 10, 15, 0, 0);
    step("R4", 1, 0, 4'd4, 50, 15, 0, 0);
    step("R2", 1, 0, 4'd0, 0, 15, 0, 0);
    step("R5", 1, 0, 4'd3, 0, 15, 0, 11);
    step("R4", 1, 0, 4'd5, 40, 3, 0, 0);
    step("R6", 1, 0, 4'd1, 200, 2, 0, 0);
    step("R6", 1, 1, 4'd1, 9, 31, 7, 0);
    step("R7", 1, 0, 4'd1, 300, 15, 2, 0);
    step("R7", 1, 0, 4'd0, 0, 15, 0, 0);
    step("R7", 1, 0, 4'd0, 0, 15, 0, 0);
    step("R8", 1, 1, 4'd1, 5, 15, 0, 0);
    step("R8", 1, 1, 4'd6, 0, 15, 0, 77);
    step("R6", 1, 1, 4'd7, 0, 31, 0, 0);
    step("R9", 1, 0, 4'd1, 999, 15, 6, 0);
    step("R9", 1, 0, 4'd1, 400, 15, 3, 0);
    step("R9", 1, 0, 4'd2, 20, 15, 0, 0);
    step("R9", 1, 0, 4'd4, 30, 15, 1, 0);
    step("R9", 1, 0, 4'd0, 0, 15, 0, 0);
    step("R10", 1, 1, 4'd9, 3, 15, 0, 0);
    for (int i = 0; i < 3; i++) step("R10", 1, 0, 4'd1, 7, 15, 0, 0);
    step("R10", 1, 0, 4'd0, 0, 15, 0, 0);
    step("R10", 1, 0, 4'd9, 0, 15, 0, 0);
    step("R5", 1, 0, 4'd6, 0, 15, 1, 900);
    step("R7", 1, 0, 4'd0, 0, 15, 0, 0);
    step("R11", 1, 1, 4'd7, 0, 15, 0, 0);
    for (int i = 0; i < 3; i++) step("R11", 1, 0, 4'd1, 8, 15, 0, 0);
    do_reset();
    step("R1", 1, 0, 4'd0, 0, 15, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule